// File: doc/BRIEF.md
# Set-Associative Read Cache with LRU Replacement

A read-only cache that sits between a requester and a slower backing memory. Each byte address is split three ways. The low bits pick a byte inside a line, the next bits pick one set, and the remaining high bits form the tag. Every way of the chosen set compares its stored tag against the incoming tag at the same time. A valid match returns the byte in the same cycle the request is presented.

On a miss the requester is held off. One whole line is fetched over a request/ready memory port and written into the set. The line goes to the lowest-numbered invalid way, or to the least recently used way once every way of the set holds data. The request then completes as an ordinary hit. Set count and way count are parameters. One way per set gives a direct-mapped cache, and one set gives a fully associative cache in which the tag is the whole line address.

Top module: `cache_sa_lookup`

## Requirements
- R1: Address fields: bits [OFF_W-1:0] are the byte offset, the next log2(SETS) bits are the set index, and the remaining high bits are the tag. Byte k of a line occupies line bits [8k+7:8k], and `cpu_data` returns the byte chosen by the offset.
- R2: When `cpu_valid` is high and the selected set holds a valid line whose tag equals the address tag, `cpu_ready` is high in that same cycle, `cpu_data` is valid, and no memory request is made.
- R3: No more than one way of a set matches a lookup in any cycle.
- R4: On a miss, `cpu_ready` stays low and `mem_req` rises in the next cycle with `mem_addr` equal to `cpu_addr >> OFF_W`. Both stay unchanged until `mem_ready` is sampled high.
- R5: `mem_line` is written into the cache in the cycle in which `mem_req` and `mem_ready` are both high. In the following cycle the held request completes with `cpu_ready` high and the byte taken from the new line.
- R6: A fill goes into an invalid way of the set if one exists, so two different lines of one set can both be resident without any eviction.
- R7: When all ways of the set are valid, the victim is the least recently used way. Both a hit and a fill make the touched way the most recent.
- R8: Reset clears every valid bit, so every first access misses, and `mem_req` is low. The initial recency order has way 0 as the oldest.
- R9: Sets are independent. Fills and hits in one set do not change what another set holds, and equal tags in different sets do not match each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Read request; held with a stable address until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address of the read |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_data | output | 8 | Byte read, valid with `cpu_ready` |
| mem_req | output | 1 | Line fetch request to backing memory |
| mem_addr | output | ADDR_W-OFF_W | Line address being fetched |
| mem_ready | input | 1 | Backing memory presents `mem_line` this cycle |
| mem_line | input | 8<<OFF_W | Fetched line, byte 0 in the low bits |

## Verification
A hit is due in the cycle the request appears, so it has zero wait cycles. A miss served by a memory that answers LAT cycles after `mem_req` rises completes exactly LAT+1 cycles after the request appears. The monitor counts the cycles each request waits and compares that count with the value the driver queued, along with the expected byte. It samples two time units after the falling edge, once the inputs driven at that edge have settled. The memory model checks each fetched line address at the moment it answers. The total number of fetches is compared with the count that the LRU sequence predicts.

// File: rtl/cache_sa_pkg.sv
package cache_sa_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fill_state_e;

   function automatic int width_min1(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 12,
   parameter int WAY_W = 1
) (
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tags,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic [WAYS-1:0]             hit_vec,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_valid[w] && (way_tags[w] == lk_tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int SETS  = 4,
   parameter int WAYS  = 2,
   parameter int IDX_W = 2,
   parameter int WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [IDX_W-1:0] rd_set,
   input  logic [WAYS-1:0]  rd_valid,
   output logic [WAY_W-1:0] victim_way
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(WAYS - 1 - w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   if (WAYS == 1) begin : g_direct
      logic unused_ok;
      assign unused_ok  = &{1'b0, rd_valid, rd_set, age_q[0]};
      assign victim_way = '0;
   end else begin : g_assoc
      always_comb begin
         logic found;
         found      = 1'b0;
         victim_way = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (!found && !rd_valid[w]) begin
               victim_way = WAY_W'(w);
               found      = 1'b1;
            end
         end
         if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
               if (age_q[rd_set][w] == OLDEST) victim_way = WAY_W'(w);
            end
         end
      end
   end
endmodule

// File: rtl/cache_fill_ctrl.sv
module cache_fill_ctrl
   import cache_sa_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_valid,
   input  logic lk_hit,
   input  logic mem_ready,
   output logic mem_req,
   output logic fill_en,
   output logic idle
);
   fill_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         FS_IDLE: if (cpu_valid && !lk_hit) state_d = FS_WAIT;
         FS_WAIT: if (mem_ready)            state_d = FS_IDLE;
         default:                           state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= FS_IDLE;
      else        state_q <= state_d;
   end

   assign idle    = (state_q == FS_IDLE);
   assign mem_req = (state_q == FS_WAIT);
   assign fill_en = mem_req && mem_ready;
endmodule

// File: rtl/cache_sa_lookup.sv
module cache_sa_lookup
   import cache_sa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 2,
   parameter int SETS   = 4,
   parameter int WAYS   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_valid,
   input  logic [ADDR_W-1:0]          cpu_addr,
   output logic                       cpu_ready,
   output logic [7:0]                 cpu_data,
   output logic                       mem_req,
   output logic [ADDR_W-OFF_W-1:0]    mem_addr,
   input  logic                       mem_ready,
   input  logic [(8<<OFF_W)-1:0]      mem_line
);
   localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 0;
   localparam int IDX_W  = width_min1(SETS);
   localparam int WAY_W  = width_min1(WAYS);
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
   localparam int LINE_W = 8 << OFF_W;

   if ((SETS & (SETS - 1)) != 0 || SETS < 1)
      $error("SETS must be a power of two");
   if ((WAYS & (WAYS - 1)) != 0 || WAYS < 1)
      $error("WAYS must be a power of two");
   if (OFF_W < 1)
      $error("OFF_W must be at least 1");
   if (TAG_W < 1)
      $error("address too narrow for offset and index");

   logic [IDX_W-1:0] set_idx;
   logic [TAG_W-1:0] lk_tag;
   logic [OFF_W-1:0] off_sel;

   if (SET_W > 0) begin : g_indexed
      assign set_idx = cpu_addr[OFF_W +: IDX_W];
   end else begin : g_single_set
      assign set_idx = '0;
   end
   assign lk_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign off_sel = cpu_addr[OFF_W-1:0];

   logic [WAYS-1:0]              valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
   logic [WAYS-1:0][LINE_W-1:0]  line_q  [SETS];

   logic [WAYS-1:0]  hit_vec;
   logic             lk_hit;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] victim_way;
   logic             fill_en;
   logic             idle;
   logic             touch_en;
   logic [WAY_W-1:0] touch_way;

   cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
      .way_valid (valid_q[set_idx]),
      .way_tags  (tag_q[set_idx]),
      .lk_tag    (lk_tag),
      .hit_vec   (hit_vec),
      .hit       (lk_hit),
      .hit_way   (hit_way)
   );

   cache_fill_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_valid (cpu_valid),
      .lk_hit    (lk_hit),
      .mem_ready (mem_ready),
      .mem_req   (mem_req),
      .fill_en   (fill_en),
      .idle      (idle)
   );

   assign touch_en  = cpu_ready || fill_en;
   assign touch_way = fill_en ? victim_way : hit_way;

   cache_lru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_set  (set_idx),
      .touch_way  (touch_way),
      .rd_set     (set_idx),
      .rd_valid   (valid_q[set_idx]),
      .victim_way (victim_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (fill_en) begin
         valid_q[set_idx][victim_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[set_idx][victim_way]  <= lk_tag;
         line_q[set_idx][victim_way] <= mem_line;
      end
   end

   logic [LINE_W-1:0] sel_line;
   assign sel_line  = line_q[set_idx][hit_way];
   assign cpu_data  = sel_line[{off_sel, 3'b000} +: 8];
   assign cpu_ready = cpu_valid && lk_hit && idle;
   assign mem_addr  = cpu_addr[ADDR_W-1:OFF_W];
endmodule

// File: rtl/cache_sa_checker.sv
module cache_sa_checker #(
   parameter int WAYS  = 2,
   parameter int BLK_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_valid,
   input logic             cpu_ready,
   input logic             mem_req,
   input logic             mem_ready,
   input logic [BLK_W-1:0] mem_addr,
   input logic [WAYS-1:0]  hit_vec
);
   a_r3_single_way: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r2_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   a_r4_miss_fetches: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_ready && !mem_req) |=> mem_req);

   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   a_r5_done_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && cpu_valid) |=> (cpu_ready || !cpu_valid));
endmodule

bind cache_sa_lookup cache_sa_checker #(.WAYS(WAYS), .BLK_W(ADDR_W-OFF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_valid (cpu_valid),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .hit_vec   (hit_vec)
);

// File: tb/sim_cache_sa_lookup.sv
module sim_cache_sa_lookup;
   localparam int ADDR_W = 16;
   localparam int OFF_W  = 2;
   localparam int SETS   = 4;
   localparam int WAYS   = 2;
   localparam int BLK_W  = ADDR_W - OFF_W;
   localparam int LINE_W = 8 << OFF_W;
   localparam int LAT    = 2;
   localparam int MISS_WAIT = LAT + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_valid = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic cpu_ready;
   logic [7:0] cpu_data;
   logic mem_req;
   logic [BLK_W-1:0] mem_addr;
   logic mem_ready = 1'b0;
   logic [LINE_W-1:0] mem_line = '0;

   always #10 clk = ~clk;

   cache_sa_lookup #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
      .cpu_ready(cpu_ready), .cpu_data(cpu_data), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_line(mem_line)
   );

   int checks = 0;
   int fails  = 0;
   int fetches = 0;
   bit finished = 0;

   typedef struct {
      logic [7:0] data;
      int         waits;
      string      tag;
   } exp_t;
   exp_t sb[$];

   logic [BLK_W-1:0] exp_blk;

   function automatic logic [7:0] pat(input int blk, input int k);
      return 8'((blk * 29 + k * 3 + 17) & 255);
   endfunction

   function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
      return ADDR_W'((t << 4) | (s << 2) | o);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // Backing memory: answers LAT falling edges after seeing the request
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
         end else if (mem_req) begin
            cnt++;
            if (cnt == LAT) begin
               check(mem_addr == exp_blk, "R4 fetch address", int'(mem_addr), int'(exp_blk));
               for (int k = 0; k < (1 << OFF_W); k++)
                  mem_line[k*8 +: 8] = pat(int'(mem_addr), k);
               mem_ready = 1'b1;
               fetches++;
            end
         end
      end
   end

   // Monitor: compares results against the scoreboard queue
   initial begin
      int waits = 0;
      forever begin
         @(negedge clk);
         #2;
         if (cpu_valid && !cpu_ready) begin
            waits++;
         end else if (cpu_valid && cpu_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "scoreboard underflow", 0, 1);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(cpu_data == e.data, {e.tag, " data"}, int'(cpu_data), int'(e.data));
               check(waits == e.waits, {e.tag, " wait cycles"}, waits, e.waits);
            end
            waits = 0;
         end
      end
   end

   task automatic access(input logic [ADDR_W-1:0] a, input bit exp_hit, input string tag);
      exp_t e;
      bit done;
      e.data  = pat(int'(a >> OFF_W), int'(a[OFF_W-1:0]));
      e.waits = exp_hit ? 0 : MISS_WAIT;
      e.tag   = tag;
      sb.push_back(e);
      exp_blk   = a[ADDR_W-1:OFF_W];
      cpu_addr  = a;
      cpu_valid = 1'b1;
      do begin
         #4;
         done = cpu_ready;
         @(negedge clk);
      end while (!done);
      cpu_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check(mem_req == 1'b0, "R8 reset no fetch", int'(mem_req), 0);
      check(cpu_ready == 1'b0, "R8 reset not ready", int'(cpu_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 cold misses, R6 fills into free ways, R1 offsets
      access(mk(1,0,0), 0, "R8 cold miss");
      access(mk(1,0,3), 1, "R1 byte 3 hit");
      access(mk(2,0,1), 0, "R6 second line miss");
      access(mk(1,0,2), 1, "R6 first line kept");
      access(mk(2,0,0), 1, "R2 hit way1");
      // R7 LRU eviction in a full set
      access(mk(3,0,0), 0, "R7 miss evicts tag1");
      access(mk(2,0,0), 1, "R7 recent line kept");
      access(mk(1,0,0), 0, "R7 evicted line misses");
      access(mk(2,0,1), 1, "R7 tag2 still held");
      access(mk(3,0,0), 0, "R7 tag3 was lru");
      // R9 set independence
      access(mk(5,1,0), 0, "R9 set1 miss");
      access(mk(6,1,2), 0, "R9 set1 free way");
      access(mk(5,1,3), 1, "R9 set1 hit");
      access(mk(2,0,3), 1, "R9 set0 untouched");
      access(mk(2,2,0), 0, "R9 same tag other set");
      // R7 hit refreshes recency; R1 widest tag
      access(mk(12'hFFF,3,3), 0, "R1 max tag miss");
      access(mk(7,3,0), 0, "R6 set3 second way");
      access(mk(12'hFFF,3,1), 1, "R7 touch oldest by hit");
      access(mk(8,3,2), 0, "R7 miss evicts tag7");
      access(mk(12'hFFF,3,0), 1, "R7 refreshed line kept");
      access(mk(7,3,0), 0, "R7 tag7 was evicted");

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R2 all responses seen", sb.size(), 0);
      check(fetches == 12, "R7 fetch count", fetches, 12);
      finish_run();
   end
endmodule